// File: doc/BRIEF.md
# Quadword Local Memory Access Unit

This block sits between a 128-entry, 128-bit register file and a byte-addressed on-chip memory that holds both code and data. A core request forms an effective address and then moves one whole 16-byte line. The address is either the sum of two registers or a register plus a sign-extended immediate. Both register operands are taken from the leftmost 32-bit word of each register. The four lowest address bits are dropped, and address bits above the memory size wrap around. The memory is a plain addressed array. It has no tags and no miss path.

A second port serves an external block-transfer engine. One request moves a fixed 128-byte block as eight back-to-back line beats. This port always takes precedence over the core port. Load results come back two cycles after the request is accepted. They are also written into the destination register.

Top module: `ls_qw_unit`

## Requirements
- R1: After reset, `cq_ready` is 1, and `ld_valid`, `dma_rvalid` and `dma_active` are 0.
- R2: With `cq_imm_mode`=0, the effective address is `rf[cq_ra][127:96] + rf[cq_rb][127:96]` (32-bit sum). Register bits 95:0 have no effect on the address.
- R3: With `cq_imm_mode`=1, the effective address is `rf[cq_ra][127:96]` plus `cq_imm` sign-extended to 32 bits.
- R4: Effective address bits 3:0 are ignored. The line accessed is effective address bits [LS_LOG2-1:4], so higher bits wrap modulo the memory size.
- R5: A load accepted in cycle n (`cq_valid`=1, `cq_store`=0, `cq_ready`=1) gives `ld_valid`=1 in cycle n+2, with `ld_rt`=`cq_rt` and `ld_data` equal to the 128-bit line. `ld_valid` is 0 in cycle n+1.
- R6: A load writes its line into register `ld_rt` at the same clock edge that raises `ld_valid`. A later store of that register writes that value.
- R7: An accepted store writes all 128 bits of `rf[cq_rt]` into the addressed line.
- R8: A burst starts in any cycle where `dma_req`=1 and no burst is running. It covers lines `{dma_blk, k}` for k = 0..7 in eight consecutive cycles. `dma_active`=1 and `dma_beat`=k during beat k. Beat 0 is the request cycle.
- R9: In a write burst (`dma_we`=1 at the request), `dma_wdata` is stored on each beat. In a read burst, `dma_rdata` holds the beat-k line with `dma_rvalid`=1 in the cycle after beat k.
- R10: `cq_ready` is 0 in every beat cycle. A core request presented then is dropped: nothing is stored, and no `ld_valid` follows.
- R11: `dma_req`, `dma_we` and `dma_blk` are ignored during beats 1..7 of a running burst.
- R12: When `rf_we`=1, `rf_wdata` is written to register `rf_widx` at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_we | input | 1 | Register file write enable |
| rf_widx | input | RF_IDX_W | Register file write index |
| rf_wdata | input | 128 | Register file write data |
| cq_valid | input | 1 | Core request valid |
| cq_store | input | 1 | 1 = store, 0 = load |
| cq_imm_mode | input | 1 | 1 = register + immediate, 0 = register + register |
| cq_ra | input | RF_IDX_W | Base register index |
| cq_rb | input | RF_IDX_W | Offset register index |
| cq_rt | input | RF_IDX_W | Load destination / store source register |
| cq_imm | input | IMM_W | Signed byte offset |
| cq_ready | output | 1 | Core request can be accepted this cycle |
| ld_valid | output | 1 | Load result valid |
| ld_rt | output | RF_IDX_W | Register index of the load result |
| ld_data | output | 128 | Loaded line |
| dma_req | input | 1 | Start a block burst |
| dma_we | input | 1 | Burst direction, 1 = write into memory |
| dma_blk | input | LS_LOG2-7 | Block index (byte address bits LS_LOG2-1:7) |
| dma_wdata | input | 128 | Write data for the current beat |
| dma_active | output | 1 | A beat uses the memory this cycle |
| dma_beat | output | 3 | Index of the current beat |
| dma_rvalid | output | 1 | Read beat data valid |
| dma_rdata | output | 128 | Read beat data |

## Verification
The assertions assume the block-transfer engine keeps `dma_wdata` valid during every write beat. They also assume the core does not expect a dropped request to be retried. The stimulus meets both assumptions by driving write data for each beat from the beat index. It deasserts `cq_valid` once the intended cycles have passed. All inputs change at the falling edge, so every request is seen at exactly one rising edge. Register-file writes from the side port never overlap a load writeback to the same register.

// File: rtl/ls_qw_unit.sv
`timescale 1ns/1ps
module ls_qw_unit #(
  parameter int LS_LOG2     = 12,
  parameter int IMM_W       = 16,
  parameter int RF_IDX_W    = 7,
  parameter int BLOCK_BYTES = 128
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 rf_we,
  input  logic [RF_IDX_W-1:0]                  rf_widx,
  input  logic [127:0]                         rf_wdata,
  input  logic                                 cq_valid,
  input  logic                                 cq_store,
  input  logic                                 cq_imm_mode,
  input  logic [RF_IDX_W-1:0]                  cq_ra,
  input  logic [RF_IDX_W-1:0]                  cq_rb,
  input  logic [RF_IDX_W-1:0]                  cq_rt,
  input  logic [IMM_W-1:0]                     cq_imm,
  output logic                                 cq_ready,
  output logic                                 ld_valid,
  output logic [RF_IDX_W-1:0]                  ld_rt,
  output logic [127:0]                         ld_data,
  input  logic                                 dma_req,
  input  logic                                 dma_we,
  input  logic [LS_LOG2-1:$clog2(BLOCK_BYTES)] dma_blk,
  input  logic [127:0]                         dma_wdata,
  output logic                                 dma_active,
  output logic [$clog2(BLOCK_BYTES/16)-1:0]    dma_beat,
  output logic                                 dma_rvalid,
  output logic [127:0]                         dma_rdata
);
  localparam int LINE_W = LS_LOG2 - 4;
  localparam int BEATS  = BLOCK_BYTES / 16;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int BLK_W  = LINE_W - BEAT_W;

  logic [127:0] rf [2**RF_IDX_W];
  logic [127:0] ls [2**LINE_W];

  // effective address from the leftmost word of each operand
  logic [31:0] base, offs;
  logic [LINE_W-1:0] core_line;
  assign base      = rf[cq_ra][127:96];
  assign offs      = cq_imm_mode ? {{(32-IMM_W){cq_imm[IMM_W-1]}}, cq_imm} : rf[cq_rb][127:96];
  assign core_line = LINE_W'((base + offs) >> 4);

  // block port
  logic              busy, we_q;
  logic [BEAT_W-1:0] cnt;
  logic [BLK_W-1:0]  blk_q;
  logic              cur_we;
  logic [LINE_W-1:0] dma_line;

  assign dma_active = busy | dma_req;
  assign cur_we     = busy ? we_q : dma_we;
  assign dma_beat   = busy ? cnt : '0;
  assign dma_line   = {busy ? blk_q : dma_blk, dma_beat};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      we_q  <= 1'b0;
      blk_q <= '0;
    end else if (!busy && dma_req) begin
      busy  <= 1'b1;
      cnt   <= BEAT_W'(1);
      we_q  <= dma_we;
      blk_q <= dma_blk;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == BEAT_W'(BEATS - 1)) busy <= 1'b0;
    end
  end

  // core port, yields to the block port
  logic accept;
  assign cq_ready = ~dma_active;
  assign accept   = cq_valid & cq_ready;

  logic                ld_v1;
  logic [RF_IDX_W-1:0] ld_rt1;
  logic [127:0]        ld_d1;

  always_ff @(posedge clk) begin
    if (dma_active && cur_we)   ls[dma_line]  <= dma_wdata;
    else if (accept && cq_store) ls[core_line] <= rf[cq_rt];
    if (dma_active && !cur_we)  dma_rdata     <= ls[dma_line];
    if (accept && !cq_store)    ld_d1         <= ls[core_line];
    ld_rt1  <= cq_rt;
    ld_rt   <= ld_rt1;
    ld_data <= ld_d1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_v1      <= 1'b0;
      ld_valid   <= 1'b0;
      dma_rvalid <= 1'b0;
    end else begin
      ld_v1      <= accept & ~cq_store;
      ld_valid   <= ld_v1;
      dma_rvalid <= dma_active & ~cur_we;
    end
  end

  always_ff @(posedge clk) begin
    if (rf_we) rf[rf_widx] <= rf_wdata;
    if (ld_v1) rf[ld_rt1]  <= ld_d1;
  end

  a_r5_load_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cq_valid && cq_ready && !cq_store) |=> !ld_valid ##1 ld_valid);

  a_r5_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(ld_v1));

  a_r8_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != BEAT_W'(BEATS - 1)) |=> (dma_active && dma_beat == BEAT_W'($past(cnt) + 1'b1)));

  a_r8_burst_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == BEAT_W'(BEATS - 1)) |=> !busy);

  a_r9_read_return: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_active && !cur_we) |=> dma_rvalid);

  a_r10_core_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_active && cq_valid) |=> !ld_v1);

  a_r11_block_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dma_req) |=> ($stable(blk_q) && $stable(we_q)));
endmodule

// File: tb/ls_qw_unit_bench.sv
`timescale 1ns/1ps
module ls_qw_unit_bench;
  localparam int LINES = 256;

  logic clk = 0, rst_n = 0;
  logic rf_we = 0; logic [6:0] rf_widx = 0; logic [127:0] rf_wdata = 0;
  logic cq_valid = 0, cq_store = 0, cq_imm_mode = 0;
  logic [6:0] cq_ra = 0, cq_rb = 0, cq_rt = 0; logic [15:0] cq_imm = 0;
  logic cq_ready, ld_valid; logic [6:0] ld_rt; logic [127:0] ld_data;
  logic dma_req = 0, dma_we = 0; logic [4:0] dma_blk = 0; logic [127:0] dma_wdata = 0;
  logic dma_active, dma_rvalid; logic [2:0] dma_beat; logic [127:0] dma_rdata;

  ls_qw_unit u_ls_qw_unit (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [127:0] model [LINES];

  function automatic logic [127:0] pat(int line);
    return {32'hA5000000 | 32'(line), 32'(line * 7919 + 3), ~32'(line), 32'(line) ^ 32'h5A5A5A5A};
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rf_write(logic [6:0] idx, logic [127:0] d);
    rf_we = 1; rf_widx = idx; rf_wdata = d;
    @(negedge clk); rf_we = 0;
  endtask

  task automatic dma_write_block(int blk);
    dma_req = 1; dma_we = 1; dma_blk = 5'(blk); dma_wdata = pat(blk * 8);
    #1 chk(cq_ready == 0 && dma_beat == 0, "R10 ready low in beat 0", 128'(cq_ready), 0);
    model[blk * 8] = pat(blk * 8);
    for (int k = 1; k < 8; k++) begin
      @(negedge clk); dma_req = 0; dma_wdata = pat(blk * 8 + k);
      model[blk * 8 + k] = pat(blk * 8 + k);
      #1 chk(dma_active && dma_beat == 3'(k), "R8 beat index", 128'(dma_beat), 128'(k));
    end
    @(negedge clk);
    #1 chk(!dma_active, "R8 burst ends after 8 beats", 128'(dma_active), 0);
  endtask

  task automatic dma_read_check(int blk, string req);
    dma_req = 1; dma_we = 0; dma_blk = 5'(blk);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); dma_req = 0;
      chk(dma_rvalid && dma_rdata == model[blk * 8 + k], req, dma_rdata, model[blk * 8 + k]);
    end
  endtask

  task automatic core_load(bit imm_mode, logic [6:0] rt, logic [15:0] imm, int exp_line, string req);
    cq_valid = 1; cq_store = 0; cq_imm_mode = imm_mode; cq_ra = 1; cq_rb = 2; cq_rt = rt; cq_imm = imm;
    @(negedge clk); cq_valid = 0;
    chk(!ld_valid, "R5 no result after one cycle", 128'(ld_valid), 0);
    @(negedge clk);
    chk(ld_valid && ld_rt == rt && ld_data == model[exp_line], req, ld_data, model[exp_line]);
  endtask

  task automatic core_store(logic [6:0] rt, logic [15:0] imm);
    cq_valid = 1; cq_store = 1; cq_imm_mode = 1; cq_ra = 1; cq_rt = rt; cq_imm = imm;
    @(negedge clk); cq_valid = 0; cq_store = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] base, off, ea;
    logic [15:0] imm;
    logic [127:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk(cq_ready && !ld_valid && !dma_rvalid && !dma_active, "R1 reset state",
           {cq_ready, ld_valid, dma_rvalid, dma_active}, 128'b1000);
    @(negedge clk);

    // R8 R9: fill every block, read every block back
    for (int b = 0; b < 32; b++) dma_write_block(b);
    for (int b = 0; b < 32; b++) dma_read_check(b, "R9 read beat data");

    // R2 R4 R12: register + register, junk in low register bits and address bits
    for (int i = 0; i < 64; i++) begin
      base = 32'(i) * 32'h00012345 + 32'(i);
      off  = 32'(i * 97) | (32'(i) << 20);
      rf_write(1, {base, {3{~base}}});
      rf_write(2, {off, {3{base}}});
      ea = base + off;
      core_load(0, 7'd10, 16'hFFFF, int'(ea[11:4]), "R2 R4 reg+reg load");
    end

    // R3 R4: register + signed immediate
    for (int i = 0; i < 64; i++) begin
      base = 32'h7000_0000 + 32'(i * 331);
      imm  = 16'(i * 523 - 16000);
      rf_write(1, {base, 96'h0});
      ea = base + {{16{imm[15]}}, imm};
      core_load(1, 7'd11, imm, int'(ea[11:4]), "R3 reg+imm load");
    end

    // R7: stores of full lines, read back by load
    for (int i = 0; i < 16; i++) begin
      v = {4{32'(i) * 32'h01010101}} ^ 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
      rf_write(3, v);
      rf_write(1, {32'(i * 16 * 13 + 5), 96'h0});
      core_store(3, 16'd0);
      model[(i * 13) % LINES] = v;
      core_load(1, 7'd12, 16'd0, (i * 13) % LINES, "R7 store then load");
    end
    dma_read_check(0, "R7 stored lines seen by block read");

    // R6: load into r20, store r20 elsewhere
    rf_write(1, {32'd40 * 16, 96'h0});
    core_load(1, 7'd20, 16'd0, 40, "R6 load result");
    core_store(20, 16'(16 * 100));
    model[140] = model[40];
    dma_read_check(17, "R6 writeback reaches register");

    // R10 R11: core requests and a second block request during a burst
    rf_write(1, {32'd200 * 16, 96'h0});
    dma_req = 1; dma_we = 1; dma_blk = 5'd3; dma_wdata = ~pat(24);
    model[24] = ~pat(24);
    for (int k = 1; k < 8; k++) begin
      @(negedge clk);
      dma_req = (k <= 6); dma_we = 0; dma_blk = 5'd10;
      dma_wdata = ~pat(24 + k); model[24 + k] = ~pat(24 + k);
      cq_valid = (k == 2 || k == 4); cq_store = (k == 2); cq_imm_mode = 1; cq_ra = 1; cq_rt = 3; cq_imm = 0;
      #1 chk(!cq_ready && dma_beat == 3'(k), "R10 core held off in burst", 128'(cq_ready), 0);
      chk(!dma_rvalid, "R11 second request not started", 128'(dma_rvalid), 0);
      chk(!ld_valid, "R10 dropped load gives no result", 128'(ld_valid), 0);
    end
    @(negedge clk); cq_valid = 0; cq_store = 0;
    chk(!ld_valid && !dma_rvalid, "R10 R11 nothing follows", {ld_valid, dma_rvalid}, 0);
    @(negedge clk);
    chk(!ld_valid && !dma_rvalid, "R10 R11 nothing follows", {ld_valid, dma_rvalid}, 0);
    dma_read_check(3, "R11 burst kept first block");
    dma_read_check(10, "R11 second block untouched");
    dma_read_check(25, "R10 dropped store had no effect");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule